// File: doc/BRIEF.md
# Banked Effective Address Generator

This block forms the 24-bit operand address for an 8/16-bit processor. The processor reaches a bank-extended address space through an 8-bit bank register placed above a 16-bit offset. A 4-bit mode code selects one of fifteen address forms. The address is built from some mix of these inputs:

- the instruction operand
- the X and Y index registers
- the direct-page base D
- the data and program bank registers
- the stack pointer

The address outputs are purely combinational. Alongside the address, the block also produces:

- A wrap mask that limits which address bits later byte steps may change.
- A dummy address. This is the address that would be seen if a page carry were not yet applied. The bus sequencer issues it during a penalty read.
- A skip flag. It tells the sequencer that a penalty cycle can be dropped.

For multi-byte accesses, the block holds the address in a register. A load strobe captures the current address and mask. Each step strobe then increments or decrements the held address, changing only the bits that the captured mask allows. Bus sequencing and instruction decode live outside this block.

Top module: `bank_ea_gen`

## Requirements
- R1: Mode 0 (absolute, data bank) gives `ea = ({dbank,16'h0000} + operand[15:0]) mod 2^24`, mask 0xFFFFFF, `dummy_ea = ea`, skip 0.
- R2: The following modes all give `dummy_ea = ea` and skip 0.
  - Mode 1 gives `ea = operand[15:0]` with mask 0x00FFFF.
  - Mode 2 gives `ea = operand` with mask 0xFFFFFF.
  - Mode 3 gives `ea = {pbank, (operand[15:0] + X) mod 2^16}` with mask 0x00FFFF.
  - Mode 4 gives `ea = (operand + X) mod 2^24` with mask 0xFFFFFF.
- R3: Modes 5 and 6 index by X; modes 7 and 8 index by Y.
  - These modes give `ea = ({dbank,16'h0} + operand[15:0] + index) mod 2^24` with mask 0xFFFFFF.
  - Here `dummy_ea[23:8] = ({dbank,16'h0} + {operand[15:8],8'h00})[23:8]` and `dummy_ea[7:0] = ea[7:0]`.
  - The read variants (6 and 8) set skip exactly when `dummy_ea == ea`. Modes 5 and 7 never set skip.
- R4: Modes 9 (direct) and 10 (direct long) give `ea = (D + operand[15:0]) mod 2^16` and `dummy_ea = ea`.
  - Skip is set exactly when `D[7:0] == 0`.
  - The mask is 0x00FFFF, except in the case covered by R5.
- R5: In mode 9 with the emulation input high and `D[7:0] == 0`, the mask is 0x0000FF. Later steps therefore stay inside the low address byte.
- R6: Modes 11 (indexed by X) and 12 (indexed by Y) form `t = D + operand[15:0] + index`.
  - In native mode, `ea = t mod 2^16`. In emulation mode, `ea = {D[15:8], t[7:0]}`.
  - In both, `dummy_ea = {D[15:8], ea[7:0]}`, the mask is 0x00FFFF, and skip is set when `D[7:0] == 0`.
- R7: Mode 13 (stack relative) gives `ea = (S + operand[15:0]) mod 2^16` with mask 0x00FFFF.
  - Mode 14 gives `ea = ({dbank,16'h0} + operand[15:0] + Y) mod 2^24` with mask 0xFFFFFF. In this mode the operand port carries the fetched pointer.
  - Both give `dummy_ea = ea` and skip 0.
- R8: While `idx_narrow` is high, only the low 8 bits of X and Y enter any sum.
- R9: Mode 15 is unused and drives `ea = 0`, `dummy_ea = 0`, mask 0xFFFFFF and skip 0.
- R10: A load strobe makes `held_addr` equal to `ea` after the next clock. A load takes priority over a step.
  - A step strobe with `step_down` low adds 1 to the held address; with `step_down` high it subtracts 1.
  - Only the bits under the captured mask change. Every bit outside the mask keeps its value.
- R11: While `rst_n` is low, `held_addr` reads 0 at once. After `rst_n` rises, the register stays cleared for two more clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the held-address register |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 4 | Addressing-mode code |
| operand | input | 24 | Instruction operand, or fetched pointer in mode 14 |
| idx_x | input | 16 | X index register |
| idx_y | input | 16 | Y index register |
| dp | input | 16 | Direct-page base D |
| dbank | input | 8 | Data bank register |
| pbank | input | 8 | Program bank register |
| sp | input | 16 | Stack pointer |
| emu | input | 1 | Emulation-mode flag |
| idx_narrow | input | 1 | High selects 8-bit index registers |
| load | input | 1 | Capture `ea` and mask into the held register |
| step | input | 1 | Step the held address by one |
| step_down | input | 1 | Step direction: 0 increments, 1 decrements |
| ea | output | 24 | Effective address |
| wrap_mask | output | 24 | Bits that byte steps may change |
| dummy_ea | output | 24 | Page-uncorrected dummy address |
| skip_cycle | output | 1 | The penalty cycle may be skipped |
| held_addr | output | 24 | Held and stepped address |

## Verification
The bench builds the block with its default widths: a 24-bit address, 16-bit registers and 8-bit pages. It sweeps every mode code against a grid of corner values:

- operands that sit on page and bank edges
- index values that do and do not cross a page
- D with a zero and a non-zero low byte
- both emulation states, both index widths, and two data banks

At these widths every page carry, bank carry and 16-bit wrap in the address sums is reachable. Stepping runs then walk the held address across a byte-mask edge and across a 16-bit-mask edge. The bench checks that the bank byte and the high byte survive those steps unchanged.

// File: rtl/bea_pkg.sv
package bea_pkg;
  localparam int PAGE_W = 8;

  typedef enum logic [3:0] {
    AM_ABS       = 4'd0,
    AM_ABS16     = 4'd1,
    AM_LONG      = 4'd2,
    AM_ABS_IND_X = 4'd3,
    AM_LONG_X    = 4'd4,
    AM_ABS_X     = 4'd5,
    AM_ABS_X_RD  = 4'd6,
    AM_ABS_Y     = 4'd7,
    AM_ABS_Y_RD  = 4'd8,
    AM_DIR       = 4'd9,
    AM_DIR_LONG  = 4'd10,
    AM_DIR_X     = 4'd11,
    AM_DIR_Y     = 4'd12,
    AM_STK       = 4'd13,
    AM_STK_IND_Y = 4'd14,
    AM_NONE      = 4'd15
  } am_e;
endpackage

// File: rtl/bea_index_mask.sv
module bea_index_mask #(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8,
  parameter int N_IDX    = 2
) (
  input  logic [N_IDX*WORD_W-1:0] idx_in,
  input  logic                    narrow,
  output logic [N_IDX*WORD_W-1:0] idx_out
);
  localparam logic [WORD_W-1:0] NARROW_MASK =
    {{(WORD_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  for (genvar g = 0; g < N_IDX; g++) begin : g_idx
    assign idx_out[g*WORD_W +: WORD_W] =
      narrow ? (idx_in[g*WORD_W +: WORD_W] & NARROW_MASK)
             : idx_in[g*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/bea_addr_calc.sv
module bea_addr_calc
  import bea_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16
) (
  input  logic [3:0]               mode,
  input  logic [ADDR_W-1:0]        operand,
  input  logic [WORD_W-1:0]        x_eff,
  input  logic [WORD_W-1:0]        y_eff,
  input  logic [WORD_W-1:0]        dp,
  input  logic [WORD_W-1:0]        sp,
  input  logic [ADDR_W-WORD_W-1:0] dbank,
  input  logic [ADDR_W-WORD_W-1:0] pbank,
  input  logic                     emu,
  output logic [ADDR_W-1:0]        ea,
  output logic [ADDR_W-1:0]        mask,
  output logic [ADDR_W-1:0]        dummy,
  output logic                     skip
);
  localparam int BANK_W = ADDR_W - WORD_W;
  localparam int PG     = PAGE_W;
  localparam logic [ADDR_W-1:0] MASK_FULL = '1;
  localparam logic [ADDR_W-1:0] MASK_WORD = {{BANK_W{1'b0}}, {WORD_W{1'b1}}};
  localparam logic [ADDR_W-1:0] MASK_PAGE = {{(ADDR_W-PG){1'b0}}, {PG{1'b1}}};

  function automatic logic [ADDR_W-1:0] zx(input logic [WORD_W-1:0] v);
    return {{BANK_W{1'b0}}, v};
  endfunction

  logic [WORD_W-1:0] op_lo, idx_sel, abs_ind_off;
  logic [WORD_W-1:0] dir_sum, dir_idx_sum, dir_idx_addr, stk_sum;
  logic [ADDR_W-1:0] bank_base, abs_sum, abs_idx_sum, abs_page_base;
  logic [ADDR_W-1:0] abs_idx_dummy, long_x_sum, stk_ind_sum;
  logic              dp_lo_zero, y_mode;

  // shared adders
  always_comb begin
    op_lo         = operand[WORD_W-1:0];
    y_mode        = (mode == AM_ABS_Y) || (mode == AM_ABS_Y_RD) || (mode == AM_DIR_Y);
    idx_sel       = y_mode ? y_eff : x_eff;
    bank_base     = {dbank, {WORD_W{1'b0}}};
    abs_sum       = bank_base + zx(op_lo);
    abs_idx_sum   = abs_sum + zx(idx_sel);
    abs_page_base = bank_base + zx({op_lo[WORD_W-1:PG], {PG{1'b0}}});
    abs_idx_dummy = {abs_page_base[ADDR_W-1:PG], abs_idx_sum[PG-1:0]};
    abs_ind_off   = op_lo + x_eff;
    long_x_sum    = operand + zx(x_eff);
    dir_sum       = dp + op_lo;
    dir_idx_sum   = dp + op_lo + idx_sel;
    dir_idx_addr  = emu ? {dp[WORD_W-1:PG], dir_idx_sum[PG-1:0]} : dir_idx_sum;
    stk_sum       = sp + op_lo;
    stk_ind_sum   = abs_sum + zx(y_eff);
    dp_lo_zero    = (dp[PG-1:0] == '0);
  end

  // mode selection
  always_comb begin
    ea    = '0;
    mask  = MASK_FULL;
    dummy = '0;
    skip  = 1'b0;
    unique case (mode)
      AM_ABS: begin
        ea = abs_sum; dummy = abs_sum;
      end
      AM_ABS16: begin
        ea = zx(op_lo); mask = MASK_WORD; dummy = zx(op_lo);
      end
      AM_LONG: begin
        ea = operand; dummy = operand;
      end
      AM_ABS_IND_X: begin
        ea = {pbank, abs_ind_off}; mask = MASK_WORD; dummy = {pbank, abs_ind_off};
      end
      AM_LONG_X: begin
        ea = long_x_sum; dummy = long_x_sum;
      end
      AM_ABS_X, AM_ABS_Y: begin
        ea = abs_idx_sum; dummy = abs_idx_dummy;
      end
      AM_ABS_X_RD, AM_ABS_Y_RD: begin
        ea = abs_idx_sum; dummy = abs_idx_dummy;
        skip = (abs_idx_dummy == abs_idx_sum);
      end
      AM_DIR: begin
        ea = zx(dir_sum); dummy = zx(dir_sum); skip = dp_lo_zero;
        mask = (dp_lo_zero && emu) ? MASK_PAGE : MASK_WORD;
      end
      AM_DIR_LONG: begin
        ea = zx(dir_sum); dummy = zx(dir_sum); skip = dp_lo_zero; mask = MASK_WORD;
      end
      AM_DIR_X, AM_DIR_Y: begin
        ea    = zx(dir_idx_addr);
        dummy = zx({dp[WORD_W-1:PG], dir_idx_addr[PG-1:0]});
        mask  = MASK_WORD;
        skip  = dp_lo_zero;
      end
      AM_STK: begin
        ea = zx(stk_sum); mask = MASK_WORD; dummy = zx(stk_sum);
      end
      AM_STK_IND_Y: begin
        ea = stk_ind_sum; dummy = stk_ind_sum;
      end
      default: begin
        ea = '0; mask = MASK_FULL; dummy = '0; skip = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bea_step_reg.sv
module bea_step_reg #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              step_down,
  input  logic [ADDR_W-1:0] ea_in,
  input  logic [ADDR_W-1:0] mask_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] mask_q,
  output logic              core_rst_n
);
  logic [1:0]        rst_sync_q;
  logic [ADDR_W-1:0] addr_d, mask_d, stepped;
  logic              upd_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  always_comb begin
    upd_en  = load | step;
    stepped = step_down ? (addr_q - 1'b1) : (addr_q + 1'b1);
    addr_d  = addr_q;
    mask_d  = mask_q;
    if (load) begin
      addr_d = ea_in;
      mask_d = mask_in;
    end else if (step) begin
      addr_d = (addr_q & ~mask_q) | (stepped & mask_q);
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      addr_q <= '0;
      mask_q <= '0;
    end else if (upd_en) begin
      addr_q <= addr_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/bank_ea_gen.sv
module bank_ea_gen #(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [3:0]               mode,
  input  logic [ADDR_W-1:0]        operand,
  input  logic [WORD_W-1:0]        idx_x,
  input  logic [WORD_W-1:0]        idx_y,
  input  logic [WORD_W-1:0]        dp,
  input  logic [ADDR_W-WORD_W-1:0] dbank,
  input  logic [ADDR_W-WORD_W-1:0] pbank,
  input  logic [WORD_W-1:0]        sp,
  input  logic                     emu,
  input  logic                     idx_narrow,
  input  logic                     load,
  input  logic                     step,
  input  logic                     step_down,
  output logic [ADDR_W-1:0]        ea,
  output logic [ADDR_W-1:0]        wrap_mask,
  output logic [ADDR_W-1:0]        dummy_ea,
  output logic                     skip_cycle,
  output logic [ADDR_W-1:0]        held_addr
);
  logic [2*WORD_W-1:0] idx_masked;
  logic [ADDR_W-1:0]   held_mask;
  logic                core_rst_n;

  bea_index_mask #(.WORD_W(WORD_W), .NARROW_W(bea_pkg::PAGE_W), .N_IDX(2)) u_idx (
    .idx_in  ({idx_y, idx_x}),
    .narrow  (idx_narrow),
    .idx_out (idx_masked)
  );

  bea_addr_calc #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_calc (
    .mode    (mode),
    .operand (operand),
    .x_eff   (idx_masked[WORD_W-1:0]),
    .y_eff   (idx_masked[2*WORD_W-1:WORD_W]),
    .dp      (dp),
    .sp      (sp),
    .dbank   (dbank),
    .pbank   (pbank),
    .emu     (emu),
    .ea      (ea),
    .mask    (wrap_mask),
    .dummy   (dummy_ea),
    .skip    (skip_cycle)
  );

  bea_step_reg #(.ADDR_W(ADDR_W)) u_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .step       (step),
    .step_down  (step_down),
    .ea_in      (ea),
    .mask_in    (wrap_mask),
    .addr_q     (held_addr),
    .mask_q     (held_mask),
    .core_rst_n (core_rst_n)
  );
endmodule

// File: rtl/bea_chk.sv
module bea_chk
  import bea_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              core_rst_n,
  input logic [3:0]        mode,
  input logic              load,
  input logic              step,
  input logic [ADDR_W-1:0] ea,
  input logic [ADDR_W-1:0] wrap_mask,
  input logic [ADDR_W-1:0] dummy_ea,
  input logic              skip_cycle,
  input logic [ADDR_W-1:0] held_addr,
  input logic [ADDR_W-1:0] held_mask
);
  // R10
  load_capture_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    load |=> (held_addr == $past(ea)));

  // R10
  step_outside_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (step && !load) |=> ((held_addr & ~$past(held_mask)) == ($past(held_addr) & ~$past(held_mask))));

  // R3
  dummy_low_byte_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (mode inside {AM_ABS_X, AM_ABS_X_RD, AM_ABS_Y, AM_ABS_Y_RD}) |-> (dummy_ea[7:0] == ea[7:0]));

  // R4
  skip_scope_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    skip_cycle |-> (mode inside {AM_ABS_X_RD, AM_ABS_Y_RD, AM_DIR, AM_DIR_LONG, AM_DIR_X, AM_DIR_Y}));

  // R9
  unused_mode_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (mode == AM_NONE) |-> (ea == '0 && wrap_mask == '1 && !skip_cycle));

  // R11
  held_clear_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(core_rst_n) |-> (held_addr == '0));
endmodule

bind bank_ea_gen bea_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .mode       (mode),
  .load       (load),
  .step       (step),
  .ea         (ea),
  .wrap_mask  (wrap_mask),
  .dummy_ea   (dummy_ea),
  .skip_cycle (skip_cycle),
  .held_addr  (held_addr),
  .held_mask  (held_mask)
);

// File: tb/sim_bank_ea_gen.sv
module sim_bank_ea_gen;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  mode;
  logic [23:0] operand;
  logic [15:0] idx_x, idx_y, dp, sp;
  logic [7:0]  dbank, pbank;
  logic        emu, idx_narrow, load, step, step_down;
  logic [23:0] ea, wrap_mask, dummy_ea, held_addr;
  logic        skip_cycle;

  int n_chk = 0;
  int n_err = 0;
  int h_exp = 0;
  int hm_exp = 0;

  int ops [4] = '{32'h000000, 32'h3400FF, 32'h8012F0, 32'hFFFFFF};
  int idxs[4] = '{32'h0000, 32'h0010, 32'h01F3, 32'hFFFF};
  int dps [4] = '{32'h0000, 32'h1200, 32'h12F8, 32'hFF01};
  int dbs [2] = '{32'h7E, 32'hFF};

  always #(CLK_P/2) clk = ~clk;

  bank_ea_gen u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .operand(operand), .idx_x(idx_x),
    .idx_y(idx_y), .dp(dp), .dbank(dbank), .pbank(pbank), .sp(sp), .emu(emu),
    .idx_narrow(idx_narrow), .load(load), .step(step), .step_down(step_down),
    .ea(ea), .wrap_mask(wrap_mask), .dummy_ea(dummy_ea), .skip_cycle(skip_cycle),
    .held_addr(held_addr)
  );

  function automatic logic [72:0] model(int m, int op, int x, int y, int d, int db,
                                        int pb, int s, bit em, bit nar);
    int xe, ye, o16, bb, idx, t, a, mk, du, sk;
    xe = nar ? (x & 'hFF) : x;
    ye = nar ? (y & 'hFF) : y;
    o16 = op & 'hFFFF;
    bb = db * 65536;
    mk = 'hFFFFFF; sk = 0; a = 0;
    idx = (m == 7 || m == 8 || m == 12) ? ye : xe;
    case (m)
      0: a = (bb + o16) & 'hFFFFFF;
      1: begin a = o16; mk = 'hFFFF; end
      2: a = op;
      3: begin a = pb * 65536 + ((o16 + xe) & 'hFFFF); mk = 'hFFFF; end
      4: a = (op + xe) & 'hFFFFFF;
      5, 6, 7, 8: a = (bb + o16 + idx) & 'hFFFFFF;
      9, 10: begin
        a = (d + o16) & 'hFFFF; mk = 'hFFFF; sk = ((d & 'hFF) == 0) ? 1 : 0;
        if (m == 9 && em && (d & 'hFF) == 0) mk = 'hFF;
      end
      11, 12: begin
        t = d + o16 + idx;
        a = em ? ((d & 'hFF00) | (t & 'hFF)) : (t & 'hFFFF);
        mk = 'hFFFF; sk = ((d & 'hFF) == 0) ? 1 : 0;
      end
      13: begin a = (s + o16) & 'hFFFF; mk = 'hFFFF; end
      14: a = (bb + o16 + ye) & 'hFFFFFF;
      default: a = 0;
    endcase
    du = a;
    if (m >= 5 && m <= 8) begin
      du = (((bb + (o16 & 'hFF00)) & 'hFFFFFF) & 'hFFFF00) | (a & 'hFF);
      sk = ((m == 6 || m == 8) && du == a) ? 1 : 0;
    end
    if (m == 11 || m == 12) du = (d & 'hFF00) | (a & 'hFF);
    return {a[23:0], mk[23:0], du[23:0], sk[0]};
  endfunction

  function automatic string tag_of(int m);
    if (m == 0) return "R1";
    if (m <= 4) return "R2";
    if (m <= 8) return "R3";
    if (m <= 10) return "R4";
    if (m <= 12) return "R6";
    if (m <= 14) return "R7";
    return "R9";
  endfunction

  task automatic chk(input string tag, input logic [72:0] act, input logic [72:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic chk_held(input string tag);
    n_chk++;
    if (held_addr !== h_exp[23:0]) begin
      n_err++;
      $display("FAIL %s: held actual=%h expected=%h", tag, held_addr, h_exp[23:0]);
    end
  endtask

  task automatic apply(int m, int op, int x, int y, int d, int db, bit em, bit nar);
    mode = m[3:0]; operand = op[23:0]; idx_x = x[15:0]; idx_y = y[15:0];
    dp = d[15:0]; dbank = db[7:0]; emu = em; idx_narrow = nar;
    #1;
  endtask

  function automatic logic [72:0] outs();
    return {ea, wrap_mask, dummy_ea, skip_cycle};
  endfunction

  task automatic do_load();
    logic [72:0] e;
    e = model(int'(mode), int'(operand), int'(idx_x), int'(idx_y), int'(dp),
              int'(dbank), int'(pbank), int'(sp), emu, idx_narrow);
    @(negedge clk) load = 1'b1;
    @(negedge clk) load = 1'b0;
    h_exp = int'(e[72:49]);
    hm_exp = int'(e[48:25]);
    chk_held("R10 load");
  endtask

  task automatic do_step(bit dn);
    int nx;
    @(negedge clk) begin step = 1'b1; step_down = dn; end
    @(negedge clk) step = 1'b0;
    nx = dn ? (h_exp - 1) : (h_exp + 1);
    h_exp = ((h_exp & ~hm_exp) | (nx & hm_exp)) & 'hFFFFFF;
    chk_held("R10 step");
  endtask

  initial begin
    rst_n = 1'b0; load = 0; step = 0; step_down = 0;
    pbank = 8'h05; sp = 16'h01F0;
    apply(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #1;
    h_exp = 0;
    chk_held("R11 reset state");
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_held("R11 after release");

    // sweep of all mode codes over corner values
    for (int mi = 0; mi < 16; mi++)
      for (int oi = 0; oi < 4; oi++)
        for (int xi = 0; xi < 4; xi++)
          for (int di = 0; di < 4; di++)
            for (int bi = 0; bi < 2; bi++)
              for (int ei = 0; ei < 2; ei++)
                for (int ni = 0; ni < 2; ni++) begin
                  apply(mi, ops[oi], idxs[xi], idxs[3-xi], dps[di], dbs[bi], ei[0], ni[0]);
                  chk(tag_of(mi), outs(),
                      model(mi, ops[oi], idxs[xi], idxs[3-xi], dps[di], dbs[bi],
                            5, 'h01F0, ei[0], ni[0]));
                end

    // R3 page crossing on a read: dummy address is one page low, no skip
    apply(6, 'h0012F0, 'h0010, 0, 0, 'h7E, 0, 0);
    chk("R3 crossing", outs(), {24'h7E1300, 24'hFFFFFF, 24'h7E1200, 1'b0});
    // R8 narrow index: 0x1234 is used as 0x34, no crossing, skip set
    apply(6, 'h001000, 'h1234, 0, 0, 'h7E, 0, 1);
    chk("R8 narrow", outs(), {24'h7E1034, 24'hFFFFFF, 24'h7E1034, 1'b1});
    // R5 low-byte wrap for plain direct in emulation mode
    apply(9, 'h0000FF, 0, 0, 'h1200, 0, 1, 0);
    chk("R5 byte mask", outs(), {24'h0012FF, 24'h0000FF, 24'h0012FF, 1'b1});

    // R10 stepping inside a byte mask keeps the high byte
    do_load();
    do_step(0);
    do_step(1);
    do_step(1);
    // R10 stepping inside a 16-bit mask keeps the program bank
    apply(3, 'h00FFF0, 'h000F, 0, 0, 0, 0, 0);
    do_load();
    for (int k = 0; k < 3; k++) do_step(0);
    for (int k = 0; k < 4; k++) do_step(1);
    // R10 full mask carries into the bank byte
    apply(0, 'h00FFFF, 0, 0, 0, 'h7E, 0, 0);
    do_load();
    do_step(0);
    do_step(1);

    // R11 asynchronous clear mid-run
    @(negedge clk) rst_n = 1'b0;
    #1;
    h_exp = 0;
    chk_held("R11 async clear");
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_held("R11 held after release");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule